// File: doc/BRIEF.md
# Two-Level Translation Fault Checker

This block takes the outcome of a two-level page-table lookup for one memory access and decides whether the access may proceed. It receives the access's low address bits, size, direction and privilege level. It also receives the first-level descriptor, the second-level descriptor (used only when the first level points at a page table) and the sixteen 2-bit domain control fields. From these it reports either a pass or exactly one fault class.

The checks run in a fixed priority. The earliest check that fails is the only fault reported. A section resolves at the first level. A page resolves at the second level but takes its domain number from the first-level descriptor. Any fault blocks the external access and stops the result from being written into the TLB. The decision is combinational, and one register stage presents it on the cycle after the request.

Top module: `fc_walk_check`

## Requirements
- R1: A request sampled with `req_valid` high produces `rsp_valid` high on the next cycle. A cycle with `req_valid` low produces all outputs zero on the next cycle. Reset clears every output.
- R2: When `align_en` is high, an access is misaligned in two cases. A halfword access (`req_size` 01) is misaligned when address bit 0 is set. A word access (`req_size` 10 or 11) is misaligned when address bits [1:0] are non-zero. A byte access (00) never faults. When `align_en` is low, no alignment fault is raised.
- R3: First-level descriptor bits [1:0] of 00 or of the reserved 11 give a section translation fault. Value 10 is a section and value 01 points to a page table.
- R4: When the first-level descriptor points to a page table and the second-level descriptor bits [1:0] are 00, a page translation fault is reported.
- R5: The domain number is first-level bits [8:5] for both sections and pages. Its control field is bits [2d+1:2d] of `dacr`. A field of 00 or 10 gives a section or page domain fault. `fault_domain` carries the domain number for domain and permission faults and is 0 otherwise.
- R6: A domain field of 11 skips the permission check and lets the access pass.
- R7: A domain field of 01 triggers the permission check. The section AP field is first-level bits [11:10] and the page AP field is second-level bits [5:4]. AP 00 denies all access. AP 01 allows privileged access only. AP 10 allows privileged access and user reads. AP 11 allows all access. A denial is a section or page permission fault.
- R8: The check order is alignment, then translation, then domain, then permission, and only the first failing check is reported.
- R9: On a fault, `access_block` is 1 and `tlb_fill_en` is 0. On a pass, `access_block` is 0 and `tlb_fill_en` is 1.
- R10: The `fault_kind` codes are:
  - 0: none
  - 1: alignment
  - 2: section translation
  - 3: page translation
  - 4: section domain
  - 5: page domain
  - 6: section permission
  - 7: page permission

  `fault_valid` is 1 exactly when the code is non-zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| req_valid | input | 1 | Access to check this cycle |
| req_addr_lo | input | 2 | Address bits [1:0] |
| req_size | input | 2 | 00 byte, 01 halfword, 10/11 word |
| req_write | input | 1 | 1 for a write |
| req_priv | input | 1 | 1 for a privileged access |
| align_en | input | 1 | Enables the alignment check |
| l1_desc | input | 12 | First-level descriptor bits [11:0] |
| l2_desc | input | 6 | Second-level descriptor bits [5:0] |
| dacr | input | 32 | Sixteen 2-bit domain control fields |
| rsp_valid | output | 1 | Result valid |
| fault_valid | output | 1 | A fault was found |
| fault_kind | output | 3 | Fault code (R10) |
| fault_domain | output | 4 | Domain of a domain or permission fault |
| access_block | output | 1 | External access suppressed |
| tlb_fill_en | output | 1 | Descriptor may be written to the TLB |

## Verification
The bound checker watches several properties on every cycle:
- the one-cycle request-to-response timing;
- the rule that a fault always blocks the access and never enables a fill;
- the agreement between the fault code and `fault_valid`;
- the priority of the alignment and translation hits over all later checks, tied to the internal hit wires.

Only the directed scenarios can show the following:
- the full access-permission table across privilege and direction, for both sections and pages;
- the page's use of the first-level domain number;
- that a manager field overrides a denying AP;
- that the reserved encodings are treated as invalid.

// File: rtl/fc_pkg.sv
package fc_pkg;

  typedef enum logic [2:0] {
    FK_NONE      = 3'd0,
    FK_ALIGN     = 3'd1,
    FK_SEC_XLAT  = 3'd2,
    FK_PAGE_XLAT = 3'd3,
    FK_SEC_DOM   = 3'd4,
    FK_PAGE_DOM  = 3'd5,
    FK_SEC_PERM  = 3'd6,
    FK_PAGE_PERM = 3'd7
  } fault_kind_e;

  localparam logic [1:0] SZ_BYTE = 2'b00;
  localparam logic [1:0] SZ_HALF = 2'b01;

  localparam logic [1:0] L1_FAULT = 2'b00;
  localparam logic [1:0] L1_TABLE = 2'b01;
  localparam logic [1:0] L1_SECT  = 2'b10;
  localparam logic [1:0] L1_RSVD  = 2'b11;

  localparam logic [1:0] DC_NOACC = 2'b00;
  localparam logic [1:0] DC_CLIENT = 2'b01;
  localparam logic [1:0] DC_RSVD  = 2'b10;
  localparam logic [1:0] DC_MGR   = 2'b11;

  // Misalignment of an access given its low address bits and size code.
  function automatic logic misaligned(input logic [1:0] lo, input logic [1:0] size);
    case (size)
      SZ_BYTE: misaligned = 1'b0;
      SZ_HALF: misaligned = lo[0];
      default: misaligned = |lo;
    endcase
  endfunction

  // Access-permission denial for a client domain.
  function automatic logic ap_denies(input logic [1:0] ap, input logic priv, input logic wr);
    case (ap)
      2'b00:   ap_denies = 1'b1;
      2'b01:   ap_denies = !priv;
      2'b10:   ap_denies = !priv && wr;
      default: ap_denies = 1'b0;
    endcase
  endfunction

endpackage

// File: rtl/fc_align.sv
module fc_align (
  input  logic       en,
  input  logic [1:0] addr_lo,
  input  logic [1:0] size,
  output logic       hit
);
  assign hit = en && fc_pkg::misaligned(addr_lo, size);
endmodule

// File: rtl/fc_domain.sv
module fc_domain #(
  parameter int NUM_DOM = 16,
  localparam int DOM_W  = $clog2(NUM_DOM),
  localparam int CTL_W  = 2 * NUM_DOM
) (
  input  logic [CTL_W-1:0] ctl_word,
  input  logic [DOM_W-1:0] dom,
  output logic             deny,
  output logic             client,
  output logic             manager
);
  logic [1:0] field [NUM_DOM];
  logic [1:0] sel;

  for (genvar g = 0; g < NUM_DOM; g++) begin : g_field
    assign field[g] = ctl_word[2*g +: 2];
  end

  assign sel     = field[dom];
  assign deny    = (sel == fc_pkg::DC_NOACC) || (sel == fc_pkg::DC_RSVD);
  assign client  = (sel == fc_pkg::DC_CLIENT);
  assign manager = (sel == fc_pkg::DC_MGR);
endmodule

// File: rtl/fc_perm.sv
module fc_perm (
  input  logic       enable,
  input  logic [1:0] ap,
  input  logic       priv,
  input  logic       wr,
  output logic       hit
);
  assign hit = enable && fc_pkg::ap_denies(ap, priv, wr);
endmodule

// File: rtl/fc_walk_check.sv
module fc_walk_check #(
  parameter int NUM_DOM    = 16,
  parameter int L1_W       = 12,
  parameter int L2_W       = 6,
  parameter int DOM_LSB    = 5,
  parameter int SEC_AP_LSB = 10,
  parameter int PG_AP_LSB  = 4,
  localparam int DOM_W     = $clog2(NUM_DOM),
  localparam int CTL_W     = 2 * NUM_DOM
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             req_valid,
  input  logic [1:0]       req_addr_lo,
  input  logic [1:0]       req_size,
  input  logic             req_write,
  input  logic             req_priv,
  input  logic             align_en,
  input  logic [L1_W-1:0]  l1_desc,
  input  logic [L2_W-1:0]  l2_desc,
  input  logic [CTL_W-1:0] dacr,
  output logic             rsp_valid,
  output logic             fault_valid,
  output logic [2:0]       fault_kind,
  output logic [DOM_W-1:0] fault_domain,
  output logic             access_block,
  output logic             tlb_fill_en
);
  import fc_pkg::*;

  // Named internal events
  logic             align_hit;
  logic             is_table;
  logic             xlat_sec_hit;
  logic             xlat_pg_hit;
  logic             dom_deny;
  logic             dom_client;
  logic             dom_mgr;
  logic             perm_hit;
  logic [DOM_W-1:0] dom_num;
  logic [1:0]       ap_sel;
  fault_kind_e      kind_d;

  fc_align u_align (
    .en      (align_en),
    .addr_lo (req_addr_lo),
    .size    (req_size),
    .hit     (align_hit)
  );

  assign is_table     = (l1_desc[1:0] == L1_TABLE);
  assign xlat_sec_hit = (l1_desc[1:0] == L1_FAULT) || (l1_desc[1:0] == L1_RSVD);
  assign xlat_pg_hit  = is_table && (l2_desc[1:0] == 2'b00);
  assign dom_num      = l1_desc[DOM_LSB +: DOM_W];

  fc_domain #(.NUM_DOM(NUM_DOM)) u_domain (
    .ctl_word (dacr),
    .dom      (dom_num),
    .deny     (dom_deny),
    .client   (dom_client),
    .manager  (dom_mgr)
  );

  assign ap_sel = is_table ? l2_desc[PG_AP_LSB +: 2] : l1_desc[SEC_AP_LSB +: 2];

  fc_perm u_perm (
    .enable (dom_client),
    .ap     (ap_sel),
    .priv   (req_priv),
    .wr     (req_write),
    .hit    (perm_hit)
  );

  // Fixed priority: alignment, translation, domain, permission.
  always_comb begin
    if (align_hit)         kind_d = FK_ALIGN;
    else if (xlat_sec_hit) kind_d = FK_SEC_XLAT;
    else if (xlat_pg_hit)  kind_d = FK_PAGE_XLAT;
    else if (dom_deny)     kind_d = is_table ? FK_PAGE_DOM : FK_SEC_DOM;
    else if (perm_hit)     kind_d = is_table ? FK_PAGE_PERM : FK_SEC_PERM;
    else                   kind_d = FK_NONE;
  end

  always_ff @(posedge clk) begin
    if (!rst_n || !req_valid) begin
      rsp_valid    <= 1'b0;
      fault_valid  <= 1'b0;
      fault_kind   <= FK_NONE;
      fault_domain <= '0;
      access_block <= 1'b0;
      tlb_fill_en  <= 1'b0;
    end else begin
      rsp_valid    <= 1'b1;
      fault_valid  <= (kind_d != FK_NONE);
      fault_kind   <= kind_d;
      fault_domain <= (kind_d >= FK_SEC_DOM) ? dom_num : '0;
      access_block <= (kind_d != FK_NONE);
      tlb_fill_en  <= (kind_d == FK_NONE);
    end
  end
endmodule

// File: rtl/fc_walk_check_sva.sv
module fc_walk_check_sva (
  input logic       clk,
  input logic       rst_n,
  input logic       req_valid,
  input logic       align_hit,
  input logic       xlat_sec_hit,
  input logic       xlat_pg_hit,
  input logic       rsp_valid,
  input logic       fault_valid,
  input logic [2:0] fault_kind,
  input logic       access_block,
  input logic       tlb_fill_en
);
  // R1
  rsp_follows_req_chk: assert property (@(posedge clk) disable iff (!rst_n)
    req_valid |=> rsp_valid);
  // R1
  idle_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
    !req_valid |=> (!rsp_valid && !fault_valid && !tlb_fill_en && !access_block));
  // R2
  align_first_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && align_hit) |=> (fault_kind == 3'd1));
  // R3
  sec_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !align_hit && xlat_sec_hit) |=> (fault_kind == 3'd2));
  // R4
  pg_xlat_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !align_hit && xlat_pg_hit) |=> (fault_kind == 3'd3));
  // R9
  fault_blocks_chk: assert property (@(posedge clk) disable iff (!rst_n)
    fault_valid |-> (access_block && !tlb_fill_en));
  // R9
  pass_fills_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (rsp_valid && !fault_valid) |-> (tlb_fill_en && !access_block));
  // R10
  kind_flag_chk: assert property (@(posedge clk) disable iff (!rst_n)
    (fault_kind != 3'd0) |-> fault_valid);
endmodule

bind fc_walk_check fc_walk_check_sva u_sva (
  .clk          (clk),
  .rst_n        (rst_n),
  .req_valid    (req_valid),
  .align_hit    (align_hit),
  .xlat_sec_hit (xlat_sec_hit),
  .xlat_pg_hit  (xlat_pg_hit),
  .rsp_valid    (rsp_valid),
  .fault_valid  (fault_valid),
  .fault_kind   (fault_kind),
  .access_block (access_block),
  .tlb_fill_en  (tlb_fill_en)
);

// File: tb/tb_fc_walk_check.sv
module tb_fc_walk_check;
  localparam int CLK_P = 10;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        req_valid = 1'b0;
  logic [1:0]  req_addr_lo = '0;
  logic [1:0]  req_size = '0;
  logic        req_write = 1'b0;
  logic        req_priv = 1'b0;
  logic        align_en = 1'b0;
  logic [11:0] l1_desc = '0;
  logic [5:0]  l2_desc = '0;
  logic [31:0] dacr = '0;
  logic        rsp_valid, fault_valid, access_block, tlb_fill_en;
  logic [2:0]  fault_kind;
  logic [3:0]  fault_domain;

  int n_tests = 0;
  int n_fail  = 0;

  fc_walk_check dut (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_addr_lo(req_addr_lo),
    .req_size(req_size), .req_write(req_write), .req_priv(req_priv),
    .align_en(align_en), .l1_desc(l1_desc), .l2_desc(l2_desc), .dacr(dacr),
    .rsp_valid(rsp_valid), .fault_valid(fault_valid), .fault_kind(fault_kind),
    .fault_domain(fault_domain), .access_block(access_block), .tlb_fill_en(tlb_fill_en)
  );

  always #(CLK_P/2) clk = ~clk;

  initial begin
    #(CLK_P * 20000);
    n_tests++; n_fail++;
    $display("FAIL watchdog: run did not complete");
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end

  // Descriptor builders (R3, R4, R7 field positions)
  function automatic logic [11:0] mk_sec(input logic [1:0] ap, input logic [3:0] dom);
    return {ap, 1'b0, dom, 3'b000, 2'b10};
  endfunction
  function automatic logic [11:0] mk_tbl(input logic [3:0] dom);
    return {3'b000, dom, 3'b000, 2'b01};
  endfunction
  function automatic logic [5:0] mk_pg(input logic [1:0] ap);
    return {ap, 2'b00, 2'b10};
  endfunction
  function automatic logic [31:0] mk_dacr(input logic [31:0] base, input int d, input logic [1:0] v);
    logic [31:0] r = base;
    r[2*d +: 2] = v;
    return r;
  endfunction

  // Reference decision restated from the requirements
  function automatic logic [2:0] model(input logic [1:0] a, input logic [1:0] sz,
      input logic wr, input logic pv, input logic aen,
      input logic [11:0] l1, input logic [5:0] l2, input logic [31:0] dc);
    logic pg;
    logic [1:0] c, ap;
    bit deny;
    if (aen && sz == 2'b01 && a[0]) return 3'd1;
    if (aen && sz[1] && a != 2'b00) return 3'd1;
    if (l1[1:0] == 2'b00 || l1[1:0] == 2'b11) return 3'd2;
    pg = (l1[1:0] == 2'b01);
    if (pg && l2[1:0] == 2'b00) return 3'd3;
    c = dc[2*int'(l1[8:5]) +: 2];
    if (c == 2'b00 || c == 2'b10) return pg ? 3'd5 : 3'd4;
    if (c == 2'b11) return 3'd0;
    ap = pg ? l2[5:4] : l1[11:10];
    deny = (ap == 2'b00) || (ap == 2'b01 && !pv) || (ap == 2'b10 && !pv && wr);
    return deny ? (pg ? 3'd7 : 3'd6) : 3'd0;
  endfunction

  task automatic send(input logic [1:0] a, input logic [1:0] sz, input logic wr,
      input logic pv, input logic aen, input logic [11:0] l1, input logic [5:0] l2,
      input logic [31:0] dc);
    req_valid = 1'b1; req_addr_lo = a; req_size = sz; req_write = wr;
    req_priv = pv; align_en = aen; l1_desc = l1; l2_desc = l2; dacr = dc;
    @(posedge clk);
    @(negedge clk);
    req_valid = 1'b0;
  endtask

  task automatic chk(input string tag, input logic [2:0] ek, input logic [3:0] ed);
    n_tests++;
    if (!rsp_valid || fault_kind !== ek || fault_domain !== ed || fault_valid !== (ek != 0)) begin
      n_fail++;
      $display("FAIL %s R10: kind=%0d dom=%0d fv=%0b rv=%0b, expected kind=%0d dom=%0d fv=%0b rv=1",
               tag, fault_kind, fault_domain, fault_valid, rsp_valid, ek, ed, ek != 0);
    end
    n_tests++;
    if (access_block !== (ek != 0) || tlb_fill_en !== (ek == 0)) begin
      n_fail++;
      $display("FAIL %s R9: block=%0b fill=%0b, expected block=%0b fill=%0b",
               tag, access_block, tlb_fill_en, ek != 0, ek == 0);
    end
  endtask

  task automatic run_model(input string tag, input logic [1:0] a, input logic [1:0] sz,
      input logic wr, input logic pv, input logic aen, input logic [11:0] l1,
      input logic [5:0] l2, input logic [31:0] dc);
    logic [2:0] ek = model(a, sz, wr, pv, aen, l1, l2, dc);
    send(a, sz, wr, pv, aen, l1, l2, dc);
    chk(tag, ek, (ek >= 3'd4) ? l1[8:5] : 4'd0);
  endtask

  task automatic t_reset;
    n_tests++;
    if (rsp_valid !== 1'b0 || fault_valid !== 1'b0 || tlb_fill_en !== 1'b0 || access_block !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 reset: rv=%0b fv=%0b fill=%0b blk=%0b, expected all 0",
               rsp_valid, fault_valid, tlb_fill_en, access_block);
    end
  endtask

  task automatic t_idle;
    send(2'b00, 2'b10, 1'b0, 1'b0, 1'b0, 12'h000, 6'h00, 32'h0);
    @(negedge clk);
    n_tests++;
    if (rsp_valid !== 1'b0 || fault_valid !== 1'b0 || fault_kind !== 3'd0 || tlb_fill_en !== 1'b0 || access_block !== 1'b0) begin
      n_fail++;
      $display("FAIL R1 idle: rv=%0b fv=%0b kind=%0d fill=%0b blk=%0b, expected all 0",
               rsp_valid, fault_valid, fault_kind, tlb_fill_en, access_block);
    end
  endtask

  task automatic t_align;
    logic [31:0] dc = {16{2'b01}};
    for (int s = 0; s < 4; s++)
      for (int a = 0; a < 4; a++)
        run_model("R2 align on", 2'(a), 2'(s), 1'b0, 1'b1, 1'b1, mk_sec(2'b11, 4'd2), 6'h0, dc);
    run_model("R2 align off", 2'b11, 2'b10, 1'b0, 1'b1, 1'b0, mk_sec(2'b11, 4'd2), 6'h0, dc);
    send(2'b01, 2'b01, 1'b0, 1'b1, 1'b1, mk_sec(2'b11, 4'd2), 6'h0, dc);
    chk("R2 half odd", 3'd1, 4'd0);
  endtask

  task automatic t_sec_xlat;
    logic [31:0] dc = {16{2'b11}};
    send(2'b00, 2'b10, 1'b0, 1'b1, 1'b1, 12'hFFC, 6'h3F, dc);
    chk("R3 l1 00", 3'd2, 4'd0);
    send(2'b00, 2'b10, 1'b0, 1'b1, 1'b1, 12'hFFF, 6'h3F, dc);
    chk("R3 l1 reserved 11", 3'd2, 4'd0);
    send(2'b00, 2'b10, 1'b1, 1'b0, 1'b1, mk_sec(2'b11, 4'd3), 6'h00, dc);
    chk("R3 section ignores l2", 3'd0, 4'd0);
  endtask

  task automatic t_page_xlat;
    logic [31:0] dc = {16{2'b11}};
    send(2'b00, 2'b10, 1'b0, 1'b1, 1'b1, mk_tbl(4'd4), 6'h3C, dc);
    chk("R4 l2 00", 3'd3, 4'd0);
    send(2'b00, 2'b10, 1'b0, 1'b1, 1'b1, mk_tbl(4'd4), 6'h01, dc);
    chk("R4 l2 01 valid", 3'd0, 4'd0);
  endtask

  task automatic t_domain;
    logic [31:0] base = {16{2'b01}};
    send(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, mk_sec(2'b11, 4'd7), 6'h0, mk_dacr(base, 7, 2'b00));
    chk("R5 section no-access", 3'd4, 4'd7);
    send(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, mk_sec(2'b11, 4'd7), 6'h0, mk_dacr(base, 7, 2'b10));
    chk("R5 section reserved", 3'd4, 4'd7);
    send(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, mk_tbl(4'd12), mk_pg(2'b11), mk_dacr(base, 12, 2'b00));
    chk("R5 page uses l1 domain", 3'd5, 4'd12);
    send(2'b00, 2'b00, 1'b0, 1'b1, 1'b0, mk_sec(2'b11, 4'd7), 6'h0, mk_dacr(base, 6, 2'b00));
    chk("R5 other domain denied", 3'd0, 4'd0);
  endtask

  task automatic t_manager;
    logic [31:0] dc = mk_dacr({16{2'b00}}, 9, 2'b11);
    send(2'b00, 2'b10, 1'b1, 1'b0, 1'b1, mk_sec(2'b00, 4'd9), 6'h0, dc);
    chk("R6 manager section", 3'd0, 4'd0);
    send(2'b00, 2'b10, 1'b1, 1'b0, 1'b1, mk_tbl(4'd9), mk_pg(2'b00), dc);
    chk("R6 manager page", 3'd0, 4'd0);
  endtask

  task automatic t_perm;
    logic [31:0] dc = {16{2'b01}};
    for (int ap = 0; ap < 4; ap++)
      for (int m = 0; m < 4; m++) begin
        run_model("R7 section perm", 2'b00, 2'b10, m[0], m[1], 1'b1, mk_sec(2'(ap), 4'd5), 6'h0, dc);
        run_model("R7 page perm", 2'b00, 2'b10, m[0], m[1], 1'b1, mk_tbl(4'd14), mk_pg(2'(ap)), dc);
      end
    send(2'b00, 2'b10, 1'b1, 1'b0, 1'b1, mk_sec(2'b10, 4'd5), 6'h0, dc);
    chk("R7 user write ro", 3'd6, 4'd5);
  endtask

  task automatic t_priority;
    logic [31:0] deny_all = {16{2'b00}};
    send(2'b10, 2'b10, 1'b1, 1'b0, 1'b1, 12'h000, 6'h00, deny_all);
    chk("R8 align over xlat", 3'd1, 4'd0);
    send(2'b00, 2'b10, 1'b1, 1'b0, 1'b1, mk_tbl(4'd3), 6'h00, deny_all);
    chk("R8 xlat over domain", 3'd3, 4'd0);
    send(2'b00, 2'b10, 1'b1, 1'b0, 1'b1, mk_sec(2'b00, 4'd3), 6'h0, deny_all);
    chk("R8 domain over perm", 3'd4, 4'd3);
  endtask

  initial begin
    @(negedge clk);
    @(negedge clk);
    t_reset;
    rst_n = 1'b1;
    @(negedge clk);
    t_reset;
    t_align;
    t_sec_xlat;
    t_page_xlat;
    t_domain;
    t_manager;
    t_perm;
    t_priority;
    t_idle;
    $display("[TB] %0d tests run, %0d failed", n_tests, n_fail);
    $finish;
  end
endmodule